// File: doc/BRIEF.md
# Mode-Multiplexed Address-High Output Port

This block is an eight-pin output port for a small microcontroller. Its pins carry one of two things. In single-chip operation they are general-purpose outputs that show a software-written data latch. In expanded operation they carry the upper byte of the internal address bus, so that external memory sees the full address. A halt request can float every pin when the halt-enable configuration bit allows it.

The register side is a plain strobe interface. A write strobe with a matching register offset loads the latch on the next clock edge. A read strobe with a matching offset returns the levels sensed at the pin-driver inputs in the same cycle. The read does not return the latch. Neither direction can stall: every strobe is taken in the cycle it is presented, so there is no back-pressure. Mode, halt and address inputs are plain control levels. The mode level is registered once before it steers the pin multiplexer.

Top module: `addr_hi_port`

## Requirements
- R1: While reset is held and after it is released, the data latch is zero, so in single-chip mode `pin_drv` is 8'h00 with all `pin_oe` bits high.
- R2: In single-chip mode (`mode_expanded`=0, as registered), `pin_drv` equals the data latch.
- R3: In expanded mode (`mode_expanded`=1, as registered), `pin_drv[n]` equals `cpu_addr[n+8]` for n = 0..7, whatever the latch holds, and follows `cpu_addr` in the same cycle.
- R4: A change on `mode_expanded` reaches the pin multiplexer at the next rising clock edge and leaves the latch contents unchanged.
- R5: When `halt_en`=0 and `halt_n`=0, `pin_oe` is 8'h00. In every other combination `pin_oe` is 8'hFF. This holds in both modes and in the same cycle.
- R6: When `rd_en`=1 and `reg_addr`=16'h1004, `rd_data` equals `pin_sense` in the same cycle, independent of the latch value.
- R7: When `wr_en`=1 and `reg_addr`=16'h1004, the latch takes `wr_data` at the rising edge. This also happens in expanded mode, where the new value first appears on the pins after a return to single-chip mode.
- R8: Writes to any other `reg_addr` leave the latch unchanged, and reads of any other `reg_addr` return 8'h00.
- R9: When `rd_en`=0, `rd_data` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Register offset of the current access |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Register write data |
| mode_expanded | input | 1 | 1 = expanded (address out), 0 = single-chip (data out) |
| cpu_addr | input | 16 | Internal address bus |
| halt_n | input | 1 | Halt request, active low |
| halt_en | input | 1 | Halt-enable configuration bit; 0 lets a halt float the pins |
| pin_sense | input | 8 | Levels sensed at the pin-driver inputs |
| pin_drv | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin output enables, 1 = drive |
| rd_data | output | 8 | Register read data |

## Verification
A latch that holds a wrong value shows on `pin_drv` one cycle after the bad write, provided the port is in single-chip mode. In expanded mode the error stays hidden until the mode returns to single-chip, and then it shows one clock later. A stuck or delayed mode register shows as address bits appearing one edge late or early. An enable or read path fault shows in the same cycle, because those paths are combinational. The bench sweeps every data value, every address high byte, every halt combination and every sensed level, so any single-bit fault in these paths is caught.

// File: rtl/addr_hi_port_pkg.sv
package addr_hi_port_pkg;
  typedef enum logic {
    PORT_SINGLE   = 1'b0,
    PORT_EXPANDED = 1'b1
  } port_mode_e;
endpackage

// File: rtl/port_data_latch.sv
module port_data_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else if (wr_hit) latch_q <= wr_data;
  end

  assert_write_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> latch_q == $past(wr_data));
  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(latch_q));
endmodule

// File: rtl/port_pin_mux.sv
module port_pin_mux
  import addr_hi_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_in,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] addr_hi,
  input  logic         halt_n,
  input  logic         halt_en,
  output logic [W-1:0] pin_drv,
  output logic [W-1:0] pin_oe
);
  port_mode_e mode_q;
  logic       float_pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PORT_SINGLE;
    else        mode_q <= port_mode_e'(mode_in);
  end

  assign float_pins = !halt_en && !halt_n;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      pin_drv[i] = (mode_q == PORT_EXPANDED) ? addr_hi[i] : latch_q[i];
      pin_oe[i]  = !float_pins;
    end
  end

  assert_mode_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(mode_in) |-> pin_drv == latch_q);
  assert_mode_expanded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mode_in) |-> pin_drv == addr_hi);
  assert_halt_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_en && !halt_n) |-> pin_oe == '0);
  assert_drive_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_en || halt_n) |-> pin_oe == '1);
endmodule

// File: rtl/port_reg_read.sv
module port_reg_read #(
  parameter int W = 8
) (
  input  logic         rd_en,
  input  logic         addr_hit,
  input  logic [W-1:0] pin_sense,
  output logic [W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en && addr_hit) rd_data = pin_sense;
  end
endmodule

// File: rtl/addr_hi_port.sv
module addr_hi_port #(
  parameter int          PORT_W     = 8,
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] REG_OFFSET = 16'h1004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              mode_expanded,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              halt_n,
  input  logic              halt_en,
  input  logic [PORT_W-1:0] pin_sense,
  output logic [PORT_W-1:0] pin_drv,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] rd_data
);
  localparam int HI_LSB = ADDR_W - PORT_W;

  logic              addr_hit;
  logic              wr_hit;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] addr_hi;

  assign addr_hit = (reg_addr == ADDR_W'(REG_OFFSET));
  assign wr_hit   = wr_en && addr_hit;
  assign addr_hi  = cpu_addr[ADDR_W-1:HI_LSB];

  port_data_latch #(.W(PORT_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .wr_data (wr_data),
    .latch_q (latch_q)
  );

  port_pin_mux #(.W(PORT_W)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_in (mode_expanded),
    .latch_q (latch_q),
    .addr_hi (addr_hi),
    .halt_n  (halt_n),
    .halt_en (halt_en),
    .pin_drv (pin_drv),
    .pin_oe  (pin_oe)
  );

  port_reg_read #(.W(PORT_W)) u_read (
    .rd_en     (rd_en),
    .addr_hit  (addr_hit),
    .pin_sense (pin_sense),
    .rd_data   (rd_data)
  );

  assert_read_sense_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == ADDR_W'(REG_OFFSET)) |-> rd_data == pin_sense);
  assert_read_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr != ADDR_W'(REG_OFFSET)) |-> rd_data == '0);
  assert_read_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
  assert_mode_keeps_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_expanded != $past(mode_expanded)) && !$past(wr_en) && $past(rst_n)
      |-> $stable(latch_q));
endmodule

// File: tb/addr_hi_port_test.sv
module addr_hi_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] OFS = 16'h1004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        mode_expanded = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        halt_n = 1'b1, halt_en = 1'b1;
  logic [7:0]  pin_sense = '0;
  logic [7:0]  pin_drv, pin_oe, rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_hi_port uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .mode_expanded(mode_expanded), .cpu_addr(cpu_addr),
    .halt_n(halt_n), .halt_en(halt_en), .pin_sense(pin_sense),
    .pin_drv(pin_drv), .pin_oe(pin_oe), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode_expanded = m;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] shadow;
    #(CLK_PERIOD * 2 + 1);
    check("R1 reset drv", pin_drv, 8'h00);
    check("R1 reset oe", pin_oe, 8'hFF);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset drv", pin_drv, 8'h00);

    // R2/R7: every data value written and shown in single-chip mode
    for (int v = 0; v < 256; v++) begin
      write_reg(OFS, 8'(v));
      check("R2 R7 single drv", pin_drv, 8'(v));
    end
    shadow = 8'hFF;

    // R8: writes elsewhere ignored, reads elsewhere zero
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a;
      a = OFS ^ (16'h1 << k);
      write_reg(a, 8'h3C);
      check("R8 stray write", pin_drv, shadow);
      rd_en = 1'b1; reg_addr = a; pin_sense = 8'hA5; #1;
      check("R8 stray read", rd_data, 8'h00);
      rd_en = 1'b0;
    end

    // R6/R9: reads return sensed levels, not latch
    for (int s = 0; s < 256; s++) begin
      @(negedge clk);
      reg_addr = OFS; pin_sense = 8'(s); rd_en = 1'b1; #1;
      check("R6 read sense", rd_data, 8'(s));
      rd_en = 1'b0; #1;
      check("R9 idle read", rd_data, 8'h00);
    end

    // R4: mode takes effect at next edge, latch kept
    write_reg(OFS, 8'h5A);
    cpu_addr = 16'hC3FF;
    @(negedge clk);
    mode_expanded = 1'b1; #1;
    check("R4 before edge", pin_drv, 8'h5A);
    @(negedge clk);
    check("R4 after edge", pin_drv, 8'hC3);

    // R3: every address high byte in expanded mode, same cycle
    for (int h = 0; h < 256; h++) begin
      @(negedge clk);
      cpu_addr = {8'(h), 8'(~h)}; #1;
      check("R3 addr hi", pin_drv, 8'(h));
    end

    // R7: write in expanded mode hidden until single-chip
    write_reg(OFS, 8'h96);
    cpu_addr = 16'h2100; #1;
    check("R7 hidden in expanded", pin_drv, 8'h21);
    set_mode(1'b0);
    check("R4 R7 back to single", pin_drv, 8'h96);

    // R5: all halt combinations, both modes
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0]);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        halt_en = c[1]; halt_n = c[0]; #1;
        check("R5 oe", pin_oe, (c == 0) ? 8'h00 : 8'hFF);
      end
    end
    halt_en = 1'b1; halt_n = 1'b1;

    // R1: reset again clears latch
    set_mode(1'b0);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 second reset", pin_drv, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 released", pin_drv, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule